// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a port of up to 32 input pins and raises one interrupt request when any pin meets the condition chosen for it. Each pin has its own trigger setting: off, low level, high level, rising edge, falling edge or either edge. When a pin meets its condition, a sticky per-pin flag is set. The flags are ORed into a single request line to the processor.

Software configures a pin by writing a 4-bit trigger code into that pin's configuration word on a simple write/read register bus. It reads the flag register to find which pins fired, then clears the flags it has handled by writing ones to them. Pin inputs are taken as asynchronous. They pass through a two-stage synchronizer before detection, and edges are found by comparing the newest synchronized sample with the one taken a clock earlier.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every configuration word reads 0, the flag register reads 0 and `irq_out` is low.
- R2: The configuration word of pin n is at byte address n*4. Its trigger code sits in bits 19:16 and reads back as written, while all other bits read 0. A write to one pin's word leaves every other pin's word unchanged.
- R3: Code 0x9 selects the rising edge. A 0-to-1 change on the pin sets the pin's flag on the third rising clock edge after the change. A flag cleared while the pin stays high remains clear, and a 1-to-0 change sets nothing.
- R4: Code 0xA selects the falling edge. A 1-to-0 change sets the flag and a 0-to-1 change does not.
- R5: Code 0xB selects either edge. Both a 0-to-1 change and a 1-to-0 change set the flag.
- R6: Code 0xC selects high level and code 0x8 selects low level. While the selected level is present, the flag is set again on every clock, so a clear has no lasting effect until the pin leaves that level.
- R7: Code 0x0 and every code not listed in R3 to R6 (for example 0x1, 0xD, 0xF) never set a flag, whatever the pin does.
- R8: The flag register is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R9: Writing 0 to a pin's configuration word stops detection on that pin but does not clear a flag that is already set.
- R10: `irq_out` is high exactly when at least one flag is set.
- R11: When a clear and a new event reach the same flag bit in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_out | output | 1 | Combined port interrupt request |

## Verification
A software clear of a flag and a new detection on the same pin can land on the same clock edge. The bench provokes this by timing a write-one to the flag register so that it commits on the exact edge where a rising edge on a configured pin reaches detection, then checks that the flag and `irq_out` stay set. The same race arises with a level trigger, where a clear issued while the level is present must be overridden at once. The bench checks both cases through the flag register and the request line.

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NPINS       = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_LSB    = 16,
  parameter int FLAG_ADDR   = 'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic             irq_out
);

  localparam logic [3:0] TRIG_LOW   = 4'h8;
  localparam logic [3:0] TRIG_RISE  = 4'h9;
  localparam logic [3:0] TRIG_FALL  = 4'hA;
  localparam logic [3:0] TRIG_EDGE  = 4'hB;
  localparam logic [3:0] TRIG_HIGH  = 4'hC;
  localparam logic [AW-1:0] FLAG_A  = AW'(FLAG_ADDR);

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] cur;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] clr;
  logic [3:0]       code_q [NPINS];

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) code_q[p] <= '0;
    end else if (bus_wr) begin
      for (int p = 0; p < NPINS; p++)
        if (bus_addr == AW'(p * 4)) code_q[p] <= bus_wdata[CODE_LSB +: 4];
    end
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      case (code_q[p])
        TRIG_LOW:  evt[p] = ~cur[p];
        TRIG_HIGH: evt[p] =  cur[p];
        TRIG_RISE: evt[p] =  cur[p] & ~prev_q[p];
        TRIG_FALL: evt[p] = ~cur[p] &  prev_q[p];
        TRIG_EDGE: evt[p] =  cur[p] ^  prev_q[p];
        default:   evt[p] = 1'b0;
      endcase
    end
  end

  assign clr = (bus_wr && bus_addr == FLAG_A) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | evt;
  end

  assign irq_out = |flag_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FLAG_A) bus_rdata = 32'(flag_q);
    for (int p = 0; p < NPINS; p++)
      if (bus_addr == AW'(p * 4)) bus_rdata[CODE_LSB +: 4] = code_q[p];
  end

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
  parameter int NPINS     = 32,
  parameter int AW        = 8,
  parameter int FLAG_ADDR = 'hA0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq_out,
  input logic [NPINS-1:0] flag_q,
  input logic [NPINS-1:0] evt
);

  logic clr_wr;
  assign clr_wr = bus_wr && bus_addr == AW'(FLAG_ADDR);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((flag_q & $past(bus_wdata[NPINS-1:0] & ~evt)) == '0)); // R8

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt))); // R11

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(flag_q) & ~flag_q) == '0)); // R9

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(evt) != '0)); // R10

endmodule

bind pin_irq_detect pin_irq_detect_chk #(
  .NPINS(NPINS), .AW(AW), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .flag_q(flag_q), .evt(evt)
);

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        irq_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  localparam logic [7:0] FLAGS = 8'hA0;

  pin_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cfg(input int pin, input logic [3:0] code);
    wr(8'(pin * 4), {12'h0, code, 16'h0});
  endtask

  task automatic pin(input int idx, input logic v, input int waitn);
    pin_in[idx] = v;
    repeat (waitn) @(negedge clk);
  endtask

  task automatic settle_clear();
    logic [31:0] d;
    pin_in = '0;
    repeat (4) @(negedge clk);
    wr(FLAGS, 32'hFFFF_FFFF);
    rd(FLAGS, d);
    chk("R8 cleanup", d, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 cfg0", d, 0);
    rd(8'h7C, d); chk("R1 cfg31", d, 0);
    rd(FLAGS, d); chk("R1 flags", d, 0);
    chk("R1 irq", {31'h0, irq_out}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R2 pin5 only code bits", d, 32'h000F_0000);
    rd(8'h10, d); chk("R2 pin4 untouched", d, 0);
    cfg(31, 4'hB);
    rd(8'h7C, d); chk("R2 pin31 readback", d, 32'h000B_0000);
    rd(8'h14, d); chk("R2 pin5 kept", d, 32'h000F_0000);
    cfg(5, 4'h0); cfg(31, 4'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    cfg(3, 4'h9);
    pin(3, 1'b1, 2);
    rd(FLAGS, d); chk("R3 latency not yet", d, 0);
    @(negedge clk);
    rd(FLAGS, d); chk("R3 rise sets", d, 32'h8);
    chk("R10 irq high", {31'h0, irq_out}, 1);
    wr(FLAGS, 32'h8);
    repeat (3) @(negedge clk);
    rd(FLAGS, d); chk("R3 single event", d, 0);
    chk("R10 irq low", {31'h0, irq_out}, 0);
    pin(3, 1'b0, 4);
    rd(FLAGS, d); chk("R3 fall ignored", d, 0);
    cfg(3, 4'h0);
    settle_clear();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    cfg(7, 4'hA);
    pin(7, 1'b1, 4);
    rd(FLAGS, d); chk("R4 rise ignored", d, 0);
    pin(7, 1'b0, 3);
    rd(FLAGS, d); chk("R4 fall sets", d, 32'h80);
    cfg(7, 4'h0);
    settle_clear();
  endtask

  task automatic t_either();
    logic [31:0] d;
    cfg(9, 4'hB);
    pin(9, 1'b1, 3);
    rd(FLAGS, d); chk("R5 rise sets", d, 32'h200);
    wr(FLAGS, 32'h200);
    pin(9, 1'b0, 3);
    rd(FLAGS, d); chk("R5 fall sets", d, 32'h200);
    cfg(9, 4'h0);
    settle_clear();
  endtask

  task automatic t_level();
    logic [31:0] d;
    cfg(12, 4'hC);
    pin(12, 1'b1, 3);
    rd(FLAGS, d); chk("R6 high sets", d, 32'h1000);
    wr(FLAGS, 32'h1000);
    rd(FLAGS, d); chk("R6 clear overridden while high", d, 32'h1000);
    pin(12, 1'b0, 3);
    wr(FLAGS, 32'h1000);
    @(negedge clk);
    rd(FLAGS, d); chk("R6 clear holds after level gone", d, 0);
    cfg(12, 4'h0);
    cfg(13, 4'h8);
    @(negedge clk);
    rd(FLAGS, d); chk("R6 low level sets", d, 32'h2000);
    cfg(13, 4'h0);
    settle_clear();
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    logic [3:0] codes [4] = '{4'h0, 4'h1, 4'hD, 4'hF};
    for (int k = 0; k < 4; k++) begin
      cfg(20, codes[k]);
      pin(20, 1'b1, 4);
      pin(20, 1'b0, 4);
      rd(FLAGS, d); chk($sformatf("R7 code %h no flag", codes[k]), d, 0);
    end
    cfg(20, 4'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    cfg(3, 4'h9); cfg(9, 4'h9);
    pin_in[3] = 1'b1; pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    wr(FLAGS, 32'h0);
    rd(FLAGS, d); chk("R8 zero write keeps", d, 32'h208);
    wr(FLAGS, 32'h8);
    rd(FLAGS, d); chk("R8 one clears bit3 only", d, 32'h200);
    chk("R10 irq from remaining flag", {31'h0, irq_out}, 1);
    wr(FLAGS, 32'h200);
    chk("R10 irq drops", {31'h0, irq_out}, 0);
    cfg(3, 4'h0); cfg(9, 4'h0);
    settle_clear();
  endtask

  task automatic t_keep();
    logic [31:0] d;
    cfg(15, 4'h9);
    pin(15, 1'b1, 3);
    cfg(15, 4'h0);
    rd(FLAGS, d); chk("R9 flag kept on disable", d, 32'h8000);
    chk("R9 irq kept", {31'h0, irq_out}, 1);
    settle_clear();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    cfg(22, 4'h9);
    wr(FLAGS, 32'h0040_0000);
    pin(22, 1'b1, 2);
    wr(FLAGS, 32'h0040_0000);
    rd(FLAGS, d); chk("R11 event beats clear", d, 32'h0040_0000);
    chk("R11 irq stays", {31'h0, irq_out}, 1);
    cfg(22, 4'h0);
    settle_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_either();
    t_level();
    t_disabled();
    t_w1c();
    t_keep();
    t_collide();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule